// File: doc/BRIEF.md
# Multi-Generation Life Tile Engine

This block advances a rectangular patch of a Game of Life field by a fixed number of generations entirely on chip. A host starts the engine and streams in one tile: each row is three adjacent packed cell words, and the tile holds the rows to be produced plus a margin of STEPS extra rows above and below. The engine keeps the tile in two row banks that trade roles every generation. It computes a whole row per cycle with a bit-parallel adder network and applies the birth-on-three, survive-on-two-or-three rule. No intermediate generation leaves the block.

Cells just outside the tile are unknown to the engine and are taken as dead. As a result, wrong values creep inward by one cell per generation from every edge of the tile. After STEPS generations only the central rows and the middle word are still exact. The engine emits only that region: OUT_ROWS words, one per cycle, each with a valid strobe. A host that covers a large field would feed overlapping tiles and stitch the exact centres together.

A parameter picks the storage width. The narrow variant keeps only the inner half of each outer word, because STEPS generations never reach further than that. The wide variant keeps all three words.

Top module: `life_tile_engine`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low and the engine waits idle for start.
- R2: A start pulse while idle opens loading. The next OUT_ROWS+2*STEPS cycles with ld_valid high supply tile rows 0, 1, 2, … from top to bottom. Each row is the vector {ld_left, ld_mid, ld_right}, in which bit i is horizontally adjacent to bits i-1 and i+1 (ld_left bit 0 touches ld_mid bit WORD_W-1, ld_mid bit 0 touches ld_right bit WORD_W-1).
- R3: ld_valid has no effect outside the loading phase, and start has no effect during loading.
- R4: Each generation updates every tile cell at the same time. A cell with exactly three live neighbours of its eight becomes live. A live cell with two live neighbours stays live. Every other cell becomes dead. Cells outside the stored tile count as dead.
- R5: Exactly STEPS generations are applied, and then the emitted word k (out_idx = k) equals the middle word of tile row STEPS+k. That value matches the one an unbounded field would reach after STEPS generations from the same cell contents.
- R6: Output consists of exactly OUT_ROWS words with out_valid high in consecutive cycles, with out_idx counting 0 to OUT_ROWS-1. out_valid is low at every other time.
- R7: start has no effect while the engine is generating or emitting. The current run completes normally.
- R8: HALF_WINDOW=1 keeps only the inner halves of the outer words (requires STEPS <= WORD_W/2). HALF_WINDOW=0 keeps all three words (requires STEPS <= WORD_W). Both produce identical output for the same input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| ld_valid | input | 1 | Tile row present on the load words |
| ld_left | input | WORD_W | Left-hand word of the tile row |
| ld_mid | input | WORD_W | Middle word of the tile row |
| ld_right | input | WORD_W | Right-hand word of the tile row |
| out_valid | output | 1 | Exact output word present |
| out_idx | output | max(1,clog2(OUT_ROWS)) | Output word number, 0 first |
| out_row | output | WORD_W | Exact middle word after STEPS generations |

## Verification
The fields are drawn at random densities from sparse to crowded, and they include live cells beyond the tile that the engine never receives. A wrong border treatment or a leak of unknown data into the emitted region therefore shows up as a mismatch against a reference run on a larger field. An empty field and a full field test the extreme neighbour counts zero and eight. A glider and a blinker that straddles the word boundary test the carries across word edges and the rule in motion. In some runs, stray start pulses and junk rows are injected during loading and generation. Because both storage variants run side by side on the same stimulus, a fault in the narrow window or in the half-word slicing appears as a difference against the same reference.

// File: rtl/life_tile_pkg.sv
package life_tile_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_STEP,
      ST_DRAIN
   } eng_state_t;

   // stored row width for a given word width and window variant
   function automatic int tile_bits(input int word_w, input int half_win);
      return (half_win != 0) ? 2 * word_w : 3 * word_w;
   endfunction

   // lowest bit of the middle word inside a stored row
   function automatic int mid_low(input int word_w, input int half_win);
      return (half_win != 0) ? word_w / 2 : word_w;
   endfunction

   function automatic int cnt_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/life_csa3.sv
module life_csa3 #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic [WIDTH-1:0] in_c,
   output logic [WIDTH-1:0] sum,
   output logic [WIDTH-1:0] carry
);
   logic [WIDTH-1:0] half_x;

   assign half_x = in_a ^ in_b;
   assign sum    = half_x ^ in_c;
   assign carry  = (in_a & in_b) | (half_x & in_c);
endmodule

// File: rtl/life_row_next.sv
module life_row_next #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] row_up,
   input  logic [WIDTH-1:0] row_cur,
   input  logic [WIDTH-1:0] row_dn,
   output logic [WIDTH-1:0] row_nxt
);
   // bit j of *_hi holds the cell at j-1, bit j of *_lo holds the cell at j+1
   logic [WIDTH-1:0] up_hi, up_lo, cur_hi, cur_lo, dn_hi, dn_lo;
   logic [WIDTH-1:0] grp [3][3];
   logic [WIDTH-1:0] s0 [3];
   logic [WIDTH-1:0] c0 [3];
   logic [WIDTH-1:0] ones_w, twos_y, twos_z, fours_x;

   assign up_hi  = row_up  << 1;
   assign up_lo  = row_up  >> 1;
   assign cur_hi = row_cur << 1;
   assign cur_lo = row_cur >> 1;
   assign dn_hi  = row_dn  << 1;
   assign dn_lo  = row_dn  >> 1;

   always_comb begin
      grp[0][0] = up_hi;  grp[0][1] = row_up; grp[0][2] = up_lo;
      grp[1][0] = cur_hi; grp[1][1] = cur_lo; grp[1][2] = dn_hi;
      grp[2][0] = row_dn; grp[2][1] = dn_lo;  grp[2][2] = '0;
   end

   // first reduction: eight neighbour planes into three sum and three carry planes
   for (genvar g = 0; g < 3; g++) begin : g_stage0
      life_csa3 #(.WIDTH(WIDTH)) u_csa (
         .in_a (grp[g][0]),
         .in_b (grp[g][1]),
         .in_c (grp[g][2]),
         .sum  (s0[g]),
         .carry(c0[g])
      );
   end

   // second reduction: count = 4*x + 2*(y+z) + w
   life_csa3 #(.WIDTH(WIDTH)) u_csa_ones (
      .in_a (s0[0]), .in_b (s0[1]), .in_c (s0[2]),
      .sum  (ones_w), .carry(twos_y)
   );
   life_csa3 #(.WIDTH(WIDTH)) u_csa_twos (
      .in_a (c0[0]), .in_b (c0[1]), .in_c (c0[2]),
      .sum  (twos_z), .carry(fours_x)
   );

   assign row_nxt = (row_cur | ones_w) & (twos_y ^ twos_z) & ~fours_x;

   // R4: an empty neighbourhood can never produce a live cell
   always_comb begin
      if (row_up == '0 && row_cur == '0 && row_dn == '0) begin
         p_empty_stays_empty_r4: assert (row_nxt == '0)
            else $error("empty rows produced live cells");
      end
   end
endmodule

// File: rtl/life_pingpong_rows.sv
module life_pingpong_rows #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_we,
   input  logic             step_we,
   input  logic             flip,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] ld_data,
   input  logic [WIDTH-1:0] step_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_up,
   output logic [WIDTH-1:0] rd_mid,
   output logic [WIDTH-1:0] rd_dn
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [WIDTH-1:0] bank_a [DEPTH];
   logic [WIDTH-1:0] bank_b [DEPTH];
   logic             sel_b;   // high: bank_b holds the current generation

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_b <= 1'b0;
      end else if (flip) begin
         sel_b <= ~sel_b;
      end
   end

   // loading fills the current bank, stepping fills the other one
   always_ff @(posedge clk) begin
      if ((ld_we && !sel_b) || (step_we && sel_b)) begin
         bank_a[wr_addr] <= ld_we ? ld_data : step_data;
      end
      if ((ld_we && sel_b) || (step_we && !sel_b)) begin
         bank_b[wr_addr] <= ld_we ? ld_data : step_data;
      end
   end

   always_comb begin
      rd_mid = sel_b ? bank_b[rd_addr] : bank_a[rd_addr];
      rd_up  = '0;
      rd_dn  = '0;
      if (rd_addr != '0) begin
         rd_up = sel_b ? bank_b[rd_addr - 1'b1] : bank_a[rd_addr - 1'b1];
      end
      if (rd_addr != LAST) begin
         rd_dn = sel_b ? bank_b[rd_addr + 1'b1] : bank_a[rd_addr + 1'b1];
      end
   end

   // R4: each completed generation hands the roles of the banks over
   p_flip_swaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> (sel_b != $past(sel_b)));

   // R4: the tile is never loaded and stepped in the same cycle
   p_single_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_we && step_we));
endmodule

// File: rtl/life_tile_ctrl.sv
module life_tile_ctrl
   import life_tile_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int STEPS    = 4,
   parameter int OUT_ROWS = 8,
   parameter int AW       = 4,
   parameter int OW       = 3,
   parameter int GW       = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ld_valid,
   output logic          ld_we,
   output logic          step_we,
   output logic          flip,
   output logic          drain_rd,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          out_valid,
   output logic [OW-1:0] out_idx
);
   localparam logic [AW-1:0] LAST_ROW = AW'(DEPTH - 1);
   localparam logic [GW-1:0] LAST_GEN = GW'(STEPS - 1);
   localparam logic [OW-1:0] LAST_OUT = OW'(OUT_ROWS - 1);
   localparam logic [AW-1:0] FIRST_EXACT = AW'(STEPS);

   eng_state_t    state;
   logic [AW-1:0] row_cnt;
   logic [GW-1:0] gen_cnt;
   logic [OW-1:0] drn_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         row_cnt   <= '0;
         gen_cnt   <= '0;
         drn_cnt   <= '0;
         out_valid <= 1'b0;
         out_idx   <= '0;
      end else begin
         out_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_LOAD;
                  row_cnt <= '0;
               end
            end
            ST_LOAD: begin
               if (ld_valid) begin
                  if (row_cnt == LAST_ROW) begin
                     row_cnt <= '0;
                     gen_cnt <= '0;
                     state   <= ST_STEP;
                  end else begin
                     row_cnt <= row_cnt + 1'b1;
                  end
               end
            end
            ST_STEP: begin
               if (row_cnt == LAST_ROW) begin
                  row_cnt <= '0;
                  if (gen_cnt == LAST_GEN) begin
                     drn_cnt <= '0;
                     state   <= ST_DRAIN;
                  end else begin
                     gen_cnt <= gen_cnt + 1'b1;
                  end
               end else begin
                  row_cnt <= row_cnt + 1'b1;
               end
            end
            ST_DRAIN: begin
               out_valid <= 1'b1;
               out_idx   <= drn_cnt;
               if (drn_cnt == LAST_OUT) begin
                  state <= ST_IDLE;
               end else begin
                  drn_cnt <= drn_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ld_we    = (state == ST_LOAD) && ld_valid;
      step_we  = (state == ST_STEP);
      flip     = step_we && (row_cnt == LAST_ROW);
      drain_rd = (state == ST_DRAIN);
      wr_addr  = row_cnt;
      rd_addr  = drain_rd ? (FIRST_EXACT + AW'(drn_cnt)) : row_cnt;
   end

   // R6: words leave only from the emitting phase
   p_valid_in_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(state) == ST_DRAIN));

   // R6: back-to-back words carry consecutive numbers
   p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> (out_idx == OW'($past(out_idx) + 1'b1)));

   // R7: a start pulse during generation never reopens loading
   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEP && start) |=> (state != ST_LOAD));

   // R5: emission is entered only from the last generation
   p_drain_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_DRAIN) |-> (($past(state) == ST_STEP) && ($past(gen_cnt) == LAST_GEN)));

   // R5: generation counter never passes its limit
   p_gen_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEP) |-> (gen_cnt <= LAST_GEN));
endmodule

// File: rtl/life_tile_engine.sv
module life_tile_engine
   import life_tile_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int STEPS       = 4,
   parameter int OUT_ROWS    = 8,
   parameter int HALF_WINDOW = 1,
   localparam int OW         = cnt_bits(OUT_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ld_valid,
   input  logic [WORD_W-1:0] ld_left,
   input  logic [WORD_W-1:0] ld_mid,
   input  logic [WORD_W-1:0] ld_right,
   output logic              out_valid,
   output logic [OW-1:0]     out_idx,
   output logic [WORD_W-1:0] out_row
);
   localparam int DEPTH  = OUT_ROWS + 2 * STEPS;
   localparam int AW     = cnt_bits(DEPTH);
   localparam int GW     = cnt_bits(STEPS);
   localparam int TW     = tile_bits(WORD_W, HALF_WINDOW);
   localparam int MID_LO = mid_low(WORD_W, HALF_WINDOW);

   // elaboration-time parameter checks
   if (STEPS < 1) begin : g_bad_steps
      $error("STEPS must be at least 1");
   end
   if (OUT_ROWS < 1) begin : g_bad_rows
      $error("OUT_ROWS must be at least 1");
   end
   if (HALF_WINDOW != 0 && (WORD_W % 2) != 0) begin : g_bad_half_w
      $error("narrow window needs an even WORD_W");
   end
   if (HALF_WINDOW != 0 && STEPS > WORD_W / 2) begin : g_bad_half_reach
      $error("STEPS exceeds half a word in the narrow window");
   end
   if (HALF_WINDOW == 0 && STEPS > WORD_W) begin : g_bad_full_reach
      $error("STEPS exceeds one word");
   end

   logic [TW-1:0] ld_row;
   logic [TW-1:0] rd_up, rd_mid, rd_dn, nxt_row;
   logic          ld_we, step_we, flip, drain_rd;
   logic [AW-1:0] wr_addr, rd_addr;

   // window variant: which bits of the three load words are stored
   if (HALF_WINDOW != 0) begin : g_narrow
      logic unused_outer;
      assign ld_row = {ld_left[WORD_W/2-1:0], ld_mid, ld_right[WORD_W-1:WORD_W/2]};
      assign unused_outer = ^{ld_left[WORD_W-1:WORD_W/2], ld_right[WORD_W/2-1:0]};
   end else begin : g_wide
      assign ld_row = {ld_left, ld_mid, ld_right};
   end

   life_tile_ctrl #(
      .DEPTH   (DEPTH),
      .STEPS   (STEPS),
      .OUT_ROWS(OUT_ROWS),
      .AW      (AW),
      .OW      (OW),
      .GW      (GW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ld_valid (ld_valid),
      .ld_we    (ld_we),
      .step_we  (step_we),
      .flip     (flip),
      .drain_rd (drain_rd),
      .wr_addr  (wr_addr),
      .rd_addr  (rd_addr),
      .out_valid(out_valid),
      .out_idx  (out_idx)
   );

   life_pingpong_rows #(
      .WIDTH(TW),
      .DEPTH(DEPTH),
      .AW   (AW)
   ) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_we    (ld_we),
      .step_we  (step_we),
      .flip     (flip),
      .wr_addr  (wr_addr),
      .ld_data  (ld_row),
      .step_data(nxt_row),
      .rd_addr  (rd_addr),
      .rd_up    (rd_up),
      .rd_mid   (rd_mid),
      .rd_dn    (rd_dn)
   );

   life_row_next #(.WIDTH(TW)) u_next (
      .row_up (rd_up),
      .row_cur(rd_mid),
      .row_dn (rd_dn),
      .row_nxt(nxt_row)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_row <= '0;
      end else if (drain_rd) begin
         out_row <= rd_mid[MID_LO +: WORD_W];
      end
   end

   // R1: nothing is emitted in the first cycle after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_life_tile_engine.sv
`timescale 1ns/1ps
module tb_life_tile_engine;
   localparam int W  = 16;
   localparam int T  = 4;
   localparam int R  = 8;
   localparam int D  = R + 2 * T;
   localparam int M  = T;
   localparam int GR = D + 2 * M;
   localparam int GC = 3 * W + 2 * M;
   localparam int OW = (R > 1) ? $clog2(R) : 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ld_valid = 1'b0;
   logic [W-1:0] ld_left = '0, ld_mid = '0, ld_right = '0;
   logic          ov_a, ov_b;
   logic [OW-1:0] oi_a, oi_b;
   logic [W-1:0]  or_a, or_b;

   always #4 clk = ~clk;   // 125 MHz

   life_tile_engine #(.WORD_W(W), .STEPS(T), .OUT_ROWS(R), .HALF_WINDOW(1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
      .ld_left(ld_left), .ld_mid(ld_mid), .ld_right(ld_right),
      .out_valid(ov_a), .out_idx(oi_a), .out_row(or_a));

   life_tile_engine #(.WORD_W(W), .STEPS(T), .OUT_ROWS(R), .HALF_WINDOW(0)) dut_full (
      .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
      .ld_left(ld_left), .ld_mid(ld_mid), .ld_right(ld_right),
      .out_valid(ov_b), .out_idx(oi_b), .out_row(or_b));

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   bit grid [GR][GC];
   bit nxt  [GR][GC];
   logic [3*W-1:0] tile [D];
   logic [W-1:0]   expw [R];

   logic [W-1:0] got_a [64], got_b [64];
   int idx_a [64], idx_b [64], cy_a [64], cy_b [64];
   int n_a = 0, n_b = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (ov_a) begin
         if (n_a < 64) begin got_a[n_a] = or_a; idx_a[n_a] = int'(oi_a); cy_a[n_a] = cyc; end
         n_a++;
      end
      if (ov_b) begin
         if (n_b < 64) begin got_b[n_b] = or_b; idx_b[n_b] = int'(oi_b); cy_b[n_b] = cyc; end
         n_b++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference rule on the larger field, dead beyond its edges
   task automatic ref_generation();
      for (int r = 0; r < GR; r++) begin
         for (int c = 0; c < GC; c++) begin
            int cnt = 0;
            for (int dr = -1; dr <= 1; dr++) begin
               for (int dc = -1; dc <= 1; dc++) begin
                  if ((dr != 0 || dc != 0) && r + dr >= 0 && r + dr < GR &&
                      c + dc >= 0 && c + dc < GC && grid[r+dr][c+dc]) cnt++;
               end
            end
            nxt[r][c] = (cnt == 3) || (grid[r][c] && cnt == 2);
         end
      end
      grid = nxt;
   endtask

   task automatic fill(input int pct);
      for (int r = 0; r < GR; r++)
         for (int c = 0; c < GC; c++)
            grid[r][c] = (($urandom % 100) < pct);
   endtask

   task automatic run_test(input string name, input string tag, input bit inject);
      for (int q = 0; q < D; q++)
         for (int p = 0; p < 3 * W; p++)
            tile[q][p] = grid[q+M][p+M];
      for (int g = 0; g < T; g++) ref_generation();
      for (int k = 0; k < R; k++)
         for (int j = 0; j < W; j++)
            expw[k][j] = grid[T+k+M][W+j+M];
      n_a = 0;
      n_b = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int q = 0; q < D; q++) begin
         ld_valid = 1'b1;
         {ld_left, ld_mid, ld_right} = tile[q];
         start = inject && (q == 3);       // R3: start during loading
         @(negedge clk);
      end
      ld_valid = 1'b0;
      start = 1'b0;
      if (inject) begin
         // R3/R7: junk rows and start pulses while generating
         repeat (3) @(negedge clk);
         for (int k = 0; k < 4; k++) begin
            start = 1'b1;
            ld_valid = 1'b1;
            ld_left = W'($urandom); ld_mid = W'($urandom); ld_right = W'($urandom);
            @(negedge clk);
         end
         start = 1'b0;
         ld_valid = 1'b0;
      end
      for (int k = 0; k < 2000 && !(n_a >= R && n_b >= R); k++) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(n_a == R, "R6", {name, " word count narrow"}, n_a, R);
      chk(n_b == R, "R6", {name, " word count wide"}, n_b, R);
      if (n_a == R && n_b == R) begin
         for (int k = 0; k < R; k++) begin
            chk(idx_a[k] == k && cy_a[k] == cy_a[0] + k, "R6", {name, " index/cycle"}, idx_a[k], k);
            chk(got_a[k] == expw[k], tag, $sformatf("%s narrow word %0d", name, k), got_a[k], expw[k]);
            chk(got_b[k] == expw[k], "R8", $sformatf("%s wide word %0d", name, k), got_b[k], expw[k]);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!ov_a && !ov_b, "R1", "out_valid in reset", {ov_a, ov_b}, 0);
      chk(or_a == '0, "R1", "out_row in reset", or_a, 0);
      rst_n = 1'b1;
      // R1/R3: idle with ld_valid toggling and no start emits nothing
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         ld_valid = k[0];
         ld_mid = W'($urandom);
      end
      ld_valid = 1'b0;
      chk(n_a == 0 && n_b == 0, "R1", "no output while idle", n_a + n_b, 0);

      fill(50);  run_test("random50 injected", "R2 R3 R4 R5 R7", 1'b1);
      fill(15);  run_test("sparse", "R2 R4 R5", 1'b0);
      fill(80);  run_test("dense", "R4 R5", 1'b0);
      fill(0);   run_test("empty", "R4 R5", 1'b0);
      fill(100); run_test("full", "R4 R5", 1'b0);
      // directed: glider in the middle word, blinker across the mid/right word edge
      fill(0);
      grid[M+6][M+W+6] = 1; grid[M+7][M+W+7] = 1;
      grid[M+8][M+W+5] = 1; grid[M+8][M+W+6] = 1; grid[M+8][M+W+7] = 1;
      grid[M+10][M+W-1] = 1; grid[M+10][M+W] = 1; grid[M+10][M+W+1] = 1;
      grid[M+4][M+2*W-1] = 1; grid[M+5][M+2*W-1] = 1; grid[M+6][M+2*W-1] = 1;
      run_test("glider+blinkers", "R2 R4 R5", 1'b0);
      fill(35);  run_test("random35 injected", "R3 R5 R7", 1'b1);
      fill(50);  run_test("random50", "R5", 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule